// File: doc/BRIEF.md
# Flash Window DMA Engine

This block is the word-level transfer engine of a serial-flash controller. It copies 32-bit little-endian words between the memory-mapped flash window and system DRAM, in either direction. It also has a checksum mode that reads flash words and sums them. Software sweeps the flash read-timing settings and compares these sums to pick a working setting. The serial protocol that sits behind the flash window is outside this block.

Software sets up the engine through six registers, selected by a 3-bit register number: control (0), flash address (1), DRAM address (2), length (3), checksum (4) and interrupt control/status (5). Writes take effect at the clock edge, and reads return the selected register combinationally. The engine has two memory master ports, one for flash and one for DRAM. Each port carries a request with write enable, address and write data. The memory accepts a request with a grant in the same cycle and answers one or more cycles later with a response strobe, read data and an error flag. A write is acknowledged by that response strobe as well. A requester holds its request, unchanged, until it is granted. The engine has at most one access outstanding, across both ports.

Top module: `flash_dma_engine`

## Requirements
- R1: After reset, all six registers read zero, the interrupt is low, and neither memory port requests.
- R2: A write to the length register (3) stores only the written value AND 0x01FFFFFC.
- R3: A write to the flash address register (1) stores 0x20000000 OR (value AND 0x0FFFFFFC). A write to the DRAM address register (2) stores 0x80000000 OR (value AND 0x3FFFFFFC).
- R4: Control bit 0 starts a transfer. With control bit 1 and bit 2 both clear, each word is read from flash and then written to DRAM. After each word the flash and DRAM addresses rise by 4 and the length falls by 4, and these values are visible during the transfer. The transfer ends when the length reaches zero. All 32 control bits read back as written, and bits 3 and up do not affect the transfer.
- R5: With control bit 1 set and bit 2 clear, each word is read from DRAM and then written to flash, with the same address and length updates.
- R6: With control bit 2 set and bit 1 clear, only flash is read. Each word is added, modulo 2^32, into the checksum register (4). The flash address and length step; the DRAM address is untouched and DRAM is never accessed.
- R7: A start with both bit 2 and bit 1 set accesses no memory and leaves the address and length registers unchanged. It completes at once.
- R8: A start with a length of zero accesses no memory and completes at once.
- R9: On completion, bit 11 of the interrupt register (5) is set. The interrupt output rises only if bit 3 of that register is set. Once raised, the interrupt stays high until the control register is written with bit 0 clear, even if software rewrites register 5.
- R10: A control write with bit 0 set is ignored while a transfer is running. Running means either that the stored bit 0 is set and status bit 11 is clear, or that the engine is still finishing an aborted access. An ignored write leaves the control register and the running transfer unchanged.
- R11: Once status bit 11 is set, a new start is accepted without clearing the status first. An accepted start clears status bit 11.
- R12: A control write with bit 0 clear stores the value and clears status bit 11, the checksum and the interrupt. It also aborts any running transfer: the engine waits for the outstanding response and then makes no further access.
- R13: If a memory response carries an error, the engine stops at once. It leaves the address and length registers at the failing word and sets status bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register number |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Contents of the selected register |
| flashReq | output | 1 | Flash port request |
| flashWe | output | 1 | Flash port write enable |
| flashAddr | output | 32 | Flash port byte address |
| flashWdata | output | 32 | Flash port write data |
| flashGnt | input | 1 | Flash port request accepted |
| flashRvalid | input | 1 | Flash port response strobe |
| flashRdata | input | 32 | Flash port read data |
| flashErr | input | 1 | Flash port error response |
| dramReq | output | 1 | DRAM port request |
| dramWe | output | 1 | DRAM port write enable |
| dramAddr | output | 32 | DRAM port byte address |
| dramWdata | output | 32 | DRAM port write data |
| dramGnt | input | 1 | DRAM port request accepted |
| dramRvalid | input | 1 | DRAM port response strobe |
| dramRdata | input | 32 | DRAM port read data |
| dramErr | input | 1 | DRAM port error response |
| irq | output | 1 | Completion interrupt, level |

## Verification
The bench issues a second start in the middle of a copy. A design that only checks the stored enable bit would accept it and switch modes partway through the transfer. It also restarts right after a completion without clearing status; a design that demands an explicit clear would stay idle. The invalid checksum request and the zero-length start are both checked through the memory access counts: a design that runs even one word would move data or change the addresses. For the error and abort cases, the bench checks that the registers stop at the failing word and that no access follows the abort. A design that steps past the error or keeps running after the stop shows different register values or higher access counts. Finally, rewriting the interrupt register must not drop the interrupt output. A design that ties the interrupt to the status bit would lower it.

// File: rtl/flash_dma_pkg.sv
package flash_dma_pkg;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_FLASH = 3'd1;
  localparam logic [2:0] SEL_DRAM  = 3'd2;
  localparam logic [2:0] SEL_LEN   = 3'd3;
  localparam logic [2:0] SEL_SUM   = 3'd4;
  localparam logic [2:0] SEL_INTR  = 3'd5;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_TOFL_BIT  = 1;
  localparam int CTRL_SUM_BIT   = 2;
  localparam int INTR_IE_BIT    = 3;
  localparam int INTR_DONE_BIT  = 11;

  typedef struct packed {
    logic latch;      // capture read data for the write half
    logic latchDram;  // captured data comes from the DRAM port
    logic accum;      // add flash read data into the checksum
    logic step;       // advance flash address, shrink length
    logic stepDram;   // also advance DRAM address
    logic setDone;    // raise completion status
  } dmaStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT
  } dmaState_e;

endpackage

// File: rtl/flash_dma_regs.sv
module flash_dma_regs
  import flash_dma_pkg::*;
#(
  parameter int          DW         = 32,
  parameter logic [31:0] FLASH_BASE = 32'h2000_0000,
  parameter logic [31:0] FLASH_MASK = 32'h0FFF_FFFC,
  parameter logic [31:0] DRAM_BASE  = 32'h8000_0000,
  parameter logic [31:0] DRAM_MASK  = 32'h3FFF_FFFC,
  parameter logic [31:0] LEN_MASK   = 32'h01FF_FFFC
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [2:0]    cfgSel,
  input  logic [DW-1:0] cfgWdata,
  output logic [DW-1:0] cfgRdata,
  input  dmaStrobe_t    strb,
  input  logic          engineActive,
  input  logic [DW-1:0] flashRdata,
  input  logic [DW-1:0] dramRdata,
  output logic          startPulse,
  output logic          stopPulse,
  output logic [1:0]    startMode,
  output logic [DW-1:0] ctrlQ,
  output logic [DW-1:0] flashAddrQ,
  output logic [DW-1:0] dramAddrQ,
  output logic [DW-1:0] lenQ,
  output logic [DW-1:0] cksumQ,
  output logic [DW-1:0] intrQ,
  output logic [DW-1:0] dataQ,
  output logic          irqQ
);

  localparam logic [DW-1:0] STEP = DW'(4);

  logic          wrCtrl;
  logic          busy;
  logic [DW-1:0] intrNext;

  assign wrCtrl     = cfgWe && (cfgSel == SEL_CTRL);
  assign busy       = (ctrlQ[CTRL_EN_BIT] && !intrQ[INTR_DONE_BIT]) || engineActive;
  assign startPulse = wrCtrl && cfgWdata[CTRL_EN_BIT] && !busy;
  assign stopPulse  = wrCtrl && !cfgWdata[CTRL_EN_BIT];
  assign startMode  = {cfgWdata[CTRL_SUM_BIT], cfgWdata[CTRL_TOFL_BIT]};

  always_comb begin
    intrNext = (cfgWe && (cfgSel == SEL_INTR)) ? cfgWdata : intrQ;
    if (startPulse || stopPulse) intrNext[INTR_DONE_BIT] = 1'b0;
    if (strb.setDone)            intrNext[INTR_DONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ      <= '0;
      flashAddrQ <= '0;
      dramAddrQ  <= '0;
      lenQ       <= '0;
      cksumQ     <= '0;
      intrQ      <= '0;
      dataQ      <= '0;
      irqQ       <= 1'b0;
    end else begin
      if (startPulse || stopPulse) ctrlQ <= cfgWdata;

      if (cfgWe && (cfgSel == SEL_FLASH))
        flashAddrQ <= FLASH_BASE | (cfgWdata & FLASH_MASK);
      else if (strb.step)
        flashAddrQ <= flashAddrQ + STEP;

      if (cfgWe && (cfgSel == SEL_DRAM))
        dramAddrQ <= DRAM_BASE | (cfgWdata & DRAM_MASK);
      else if (strb.step && strb.stepDram)
        dramAddrQ <= dramAddrQ + STEP;

      if (cfgWe && (cfgSel == SEL_LEN))
        lenQ <= cfgWdata & LEN_MASK;
      else if (strb.step)
        lenQ <= lenQ - STEP;

      if (stopPulse)       cksumQ <= '0;
      else if (strb.accum) cksumQ <= cksumQ + flashRdata;

      intrQ <= intrNext;

      if (stopPulse)                                irqQ <= 1'b0;
      else if (strb.setDone && intrQ[INTR_IE_BIT])  irqQ <= 1'b1;

      if (strb.latch) dataQ <= strb.latchDram ? dramRdata : flashRdata;
    end
  end

  always_comb begin
    unique case (cfgSel)
      SEL_CTRL:  cfgRdata = ctrlQ;
      SEL_FLASH: cfgRdata = flashAddrQ;
      SEL_DRAM:  cfgRdata = dramAddrQ;
      SEL_LEN:   cfgRdata = lenQ;
      SEL_SUM:   cfgRdata = cksumQ;
      SEL_INTR:  cfgRdata = intrQ;
      default:   cfgRdata = '0;
    endcase
  end

endmodule

// File: rtl/flash_dma_ctrl.sv
module flash_dma_ctrl
  import flash_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       stopPulse,
  input  logic [1:0] startMode,
  input  logic       lenZero,
  input  logic       flashGnt,
  input  logic       flashRvalid,
  input  logic       flashErr,
  input  logic       dramGnt,
  input  logic       dramRvalid,
  input  logic       dramErr,
  output logic       flashReq,
  output logic       flashWe,
  output logic       dramReq,
  output logic       dramWe,
  output logic       engineActive,
  output dmaStrobe_t strb
);

  dmaState_e stateQ, stateNext;
  logic      abortQ;
  logic      abortNow;
  logic      sumQ, toFlashQ;
  logic      rdFromDram;
  logic      rdGnt, rdValid, rdErr;
  logic      wrGnt, wrValid, wrErr;
  logic      rdReq, wrReq;

  assign abortNow   = abortQ || stopPulse;
  assign rdFromDram = toFlashQ && !sumQ;

  assign rdGnt   = rdFromDram ? dramGnt    : flashGnt;
  assign rdValid = rdFromDram ? dramRvalid : flashRvalid;
  assign rdErr   = rdFromDram ? dramErr    : flashErr;
  assign wrGnt   = rdFromDram ? flashGnt    : dramGnt;
  assign wrValid = rdFromDram ? flashRvalid : dramRvalid;
  assign wrErr   = rdFromDram ? flashErr    : dramErr;

  always_comb begin
    stateNext = stateQ;
    strb      = '0;
    rdReq     = 1'b0;
    wrReq     = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (startPulse) stateNext = ST_CHECK;
      ST_CHECK: begin
        if (abortNow) begin
          stateNext = ST_IDLE;
        end else if (lenZero || (sumQ && toFlashQ)) begin
          strb.setDone = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          stateNext = ST_RD_REQ;
        end
      end
      ST_RD_REQ: begin
        rdReq = 1'b1;
        if (rdGnt) stateNext = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (rdValid) begin
          if (abortNow) begin
            stateNext = ST_IDLE;
          end else if (rdErr) begin
            strb.setDone = 1'b1;
            stateNext    = ST_IDLE;
          end else if (sumQ) begin
            strb.accum = 1'b1;
            strb.step  = 1'b1;
            stateNext  = ST_CHECK;
          end else begin
            strb.latch     = 1'b1;
            strb.latchDram = rdFromDram;
            stateNext      = ST_WR_REQ;
          end
        end
      end
      ST_WR_REQ: begin
        wrReq = 1'b1;
        if (wrGnt) stateNext = ST_WR_WAIT;
      end
      ST_WR_WAIT: begin
        if (wrValid) begin
          if (abortNow) begin
            stateNext = ST_IDLE;
          end else if (wrErr) begin
            strb.setDone = 1'b1;
            stateNext    = ST_IDLE;
          end else begin
            strb.step     = 1'b1;
            strb.stepDram = 1'b1;
            stateNext     = ST_CHECK;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      abortQ   <= 1'b0;
      sumQ     <= 1'b0;
      toFlashQ <= 1'b0;
    end else begin
      stateQ <= stateNext;
      abortQ <= (stateNext != ST_IDLE) && abortNow;
      if (startPulse) begin
        sumQ     <= startMode[1];
        toFlashQ <= startMode[0];
      end
    end
  end

  assign flashReq     = (rdReq && !rdFromDram) || (wrReq && rdFromDram);
  assign flashWe      = wrReq && rdFromDram;
  assign dramReq      = (rdReq && rdFromDram) || (wrReq && !rdFromDram);
  assign dramWe       = wrReq && !rdFromDram;
  assign engineActive = (stateQ != ST_IDLE);

endmodule

// File: rtl/flash_dma_engine.sv
module flash_dma_engine
  import flash_dma_pkg::*;
#(
  parameter int          DW              = 32,
  parameter logic [31:0] FLASH_BASE      = 32'h2000_0000,
  parameter int          FLASH_SPAN_BITS = 28,
  parameter logic [31:0] DRAM_BASE       = 32'h8000_0000,
  parameter int          DRAM_SPAN_BITS  = 30,
  parameter int          LEN_BITS        = 25
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [2:0]    cfgSel,
  input  logic [DW-1:0] cfgWdata,
  output logic [DW-1:0] cfgRdata,
  output logic          flashReq,
  output logic          flashWe,
  output logic [DW-1:0] flashAddr,
  output logic [DW-1:0] flashWdata,
  input  logic          flashGnt,
  input  logic          flashRvalid,
  input  logic [DW-1:0] flashRdata,
  input  logic          flashErr,
  output logic          dramReq,
  output logic          dramWe,
  output logic [DW-1:0] dramAddr,
  output logic [DW-1:0] dramWdata,
  input  logic          dramGnt,
  input  logic          dramRvalid,
  input  logic [DW-1:0] dramRdata,
  input  logic          dramErr,
  output logic          irq
);

  localparam logic [31:0] WORD_CLR   = ~32'h3;
  localparam logic [31:0] FLASH_MASK = ((32'h1 << FLASH_SPAN_BITS) - 32'h1) & WORD_CLR;
  localparam logic [31:0] DRAM_MASK  = ((32'h1 << DRAM_SPAN_BITS) - 32'h1) & WORD_CLR;
  localparam logic [31:0] LEN_MASK   = ((32'h1 << LEN_BITS) - 32'h1) & WORD_CLR;

  dmaStrobe_t    strb;
  logic          startPulse, stopPulse, engineActive;
  logic [1:0]    startMode;
  logic [DW-1:0] ctrlQ, lenQ, cksumQ, intrQ, dataQ;

  flash_dma_regs #(
    .DW(DW), .FLASH_BASE(FLASH_BASE), .FLASH_MASK(FLASH_MASK),
    .DRAM_BASE(DRAM_BASE), .DRAM_MASK(DRAM_MASK), .LEN_MASK(LEN_MASK)
  ) i_regs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .strb(strb), .engineActive(engineActive),
    .flashRdata(flashRdata), .dramRdata(dramRdata),
    .startPulse(startPulse), .stopPulse(stopPulse), .startMode(startMode),
    .ctrlQ(ctrlQ), .flashAddrQ(flashAddr), .dramAddrQ(dramAddr), .lenQ(lenQ),
    .cksumQ(cksumQ), .intrQ(intrQ), .dataQ(dataQ), .irqQ(irq)
  );

  flash_dma_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
    .startMode(startMode), .lenZero(lenQ == '0),
    .flashGnt(flashGnt), .flashRvalid(flashRvalid), .flashErr(flashErr),
    .dramGnt(dramGnt), .dramRvalid(dramRvalid), .dramErr(dramErr),
    .flashReq(flashReq), .flashWe(flashWe), .dramReq(dramReq), .dramWe(dramWe),
    .engineActive(engineActive), .strb(strb)
  );

  assign flashWdata = dataQ;
  assign dramWdata  = dataQ;

endmodule

// File: rtl/flash_dma_checker.sv
module flash_dma_checker
  import flash_dma_pkg::*;
#(
  parameter int LEN_BITS = 25
) (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWe,
  input logic [2:0]  cfgSel,
  input logic [31:0] cfgWdata,
  input logic        flashReq,
  input logic        flashGnt,
  input logic [31:0] flashAddr,
  input logic        dramReq,
  input logic        dramGnt,
  input logic [31:0] dramAddr,
  input logic        irq,
  input logic [31:0] ctrlQ,
  input logic [31:0] intrQ,
  input logic [31:0] cksumQ,
  input logic [31:0] lenQ
);

  localparam logic [31:0] LEN_OK = ((32'h1 << LEN_BITS) - 32'h1) & ~32'h3;

  logic wrCtrl;
  assign wrCtrl = cfgWe && (cfgSel == SEL_CTRL);

  a_r2_len_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (lenQ & ~LEN_OK) == 32'h0);

  a_r3_word_aligned_access: assert property (@(posedge clk) disable iff (!rstN)
    (flashReq |-> flashAddr[1:0] == 2'b00) and (dramReq |-> dramAddr[1:0] == 2'b00));

  a_r4_one_port_at_a_time: assert property (@(posedge clk) disable iff (!rstN)
    !(flashReq && dramReq));

  a_r4_flash_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (flashReq && !flashGnt) |=> (flashReq && $stable(flashAddr)));

  a_r4_dram_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (dramReq && !dramGnt) |=> (dramReq && $stable(dramAddr)));

  a_r9_irq_needs_done_and_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (intrQ[INTR_DONE_BIT] && intrQ[INTR_IE_BIT]));

  a_r10_start_refused_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && cfgWdata[CTRL_EN_BIT] && ctrlQ[CTRL_EN_BIT] && !intrQ[INTR_DONE_BIT])
      |=> $stable(ctrlQ));

  a_r12_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !cfgWdata[CTRL_EN_BIT])
      |=> (!irq && !intrQ[INTR_DONE_BIT] && cksumQ == 32'h0));

endmodule

bind flash_dma_engine flash_dma_checker i_checker (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
  .flashReq(flashReq), .flashGnt(flashGnt), .flashAddr(flashAddr),
  .dramReq(dramReq), .dramGnt(dramGnt), .dramAddr(dramAddr), .irq(irq),
  .ctrlQ(ctrlQ), .intrQ(intrQ), .cksumQ(cksumQ), .lenQ(lenQ)
);

// File: tb/test_flash_dma_engine.sv
module test_flash_dma_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = 3'd0;
  logic [31:0] cfgWdata = 32'h0;
  logic [31:0] cfgRdata;
  logic        flashReq, flashWe, dramReq, dramWe, irq;
  logic [31:0] flashAddr, flashWdata, dramAddr, dramWdata;
  logic        flashRvalid = 1'b0, flashErr = 1'b0, dramRvalid = 1'b0, dramErr = 1'b0;
  logic [31:0] flashRdata = 32'h0, dramRdata = 32'h0;
  logic        flashGnt, dramGnt;

  logic [31:0] fMem [64];
  logic [31:0] dMem [64];
  int          flashAcc = 0;
  int          dramAcc = 0;
  logic        errEn = 1'b0;
  logic [31:0] errAddr = 32'h0;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  assign flashGnt = flashReq;
  assign dramGnt  = dramReq;

  flash_dma_engine i_flash_dma_engine (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata),
    .flashReq(flashReq), .flashWe(flashWe), .flashAddr(flashAddr), .flashWdata(flashWdata),
    .flashGnt(flashGnt), .flashRvalid(flashRvalid), .flashRdata(flashRdata), .flashErr(flashErr),
    .dramReq(dramReq), .dramWe(dramWe), .dramAddr(dramAddr), .dramWdata(dramWdata),
    .dramGnt(dramGnt), .dramRvalid(dramRvalid), .dramRdata(dramRdata), .dramErr(dramErr),
    .irq(irq)
  );

  // memory responders: grant at once, answer one cycle later
  always @(posedge clk) begin
    flashRvalid <= 1'b0;
    flashErr    <= 1'b0;
    if (flashReq) begin
      flashAcc    <= flashAcc + 1;
      flashRvalid <= 1'b1;
      flashRdata  <= fMem[flashAddr[7:2]];
      flashErr    <= errEn && (flashAddr == errAddr);
      if (flashWe && !(errEn && flashAddr == errAddr)) fMem[flashAddr[7:2]] <= flashWdata;
    end
  end

  always @(posedge clk) begin
    dramRvalid <= 1'b0;
    dramErr    <= 1'b0;
    if (dramReq) begin
      dramAcc    <= dramAcc + 1;
      dramRvalid <= 1'b1;
      dramRdata  <= dMem[dramAddr[7:2]];
      if (dramWe) dMem[dramAddr[7:2]] <= dramWdata;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] val);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = val;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] val);
    cfgSel = sel;
    #1;
    val = cfgRdata;
  endtask

  task automatic waitDone(input string req);
    logic [31:0] v;
    bit seen = 0;
    for (int i = 0; i < 500; i++) begin
      rd(3'd5, v);
      if (v[11]) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(req, "completion status", 32'(seen), 32'd1);
  endtask

  task automatic stopEngine();
    wr(3'd0, 32'h0);
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), v);
      chk("R1", $sformatf("register %0d after reset", s), v, 32'h0);
    end
    chk("R1", "irq after reset", 32'(irq), 32'h0);
    chk("R1", "requests after reset", 32'({flashReq, dramReq}), 32'h0);
  endtask

  task automatic testMasks();
    logic [31:0] v;
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); chk("R2", "length mask", v, 32'h01FF_FFFC);
    wr(3'd3, 32'h0000_0013); rd(3'd3, v); chk("R2", "length low bits", v, 32'h0000_0010);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); chk("R3", "flash addr mask", v, 32'h2FFF_FFFC);
    wr(3'd1, 32'h0000_0013); rd(3'd1, v); chk("R3", "flash addr base", v, 32'h2000_0010);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); chk("R3", "dram addr mask", v, 32'hBFFF_FFFC);
  endtask

  task automatic testCopyToDram();
    logic [31:0] v;
    wr(3'd1, 32'h20); wr(3'd2, 32'h40); wr(3'd3, 32'h10);
    wr(3'd5, 32'h8);
    wr(3'd0, 32'h0000_00F9);
    repeat (5) @(negedge clk);
    rd(3'd3, v); chk("R4", "live length after first word", v, 32'hC);
    rd(3'd1, v); chk("R4", "live flash addr after first word", v, 32'h2000_0024);
    wr(3'd0, 32'h0000_0005);
    rd(3'd0, v); chk("R10", "control after refused start", v, 32'h0000_00F9);
    waitDone("R4");
    for (int i = 0; i < 4; i++)
      chk("R4", $sformatf("dram word %0d", i), dMem[16+i], fMem[8+i]);
    rd(3'd1, v); chk("R4", "final flash addr", v, 32'h2000_0030);
    rd(3'd2, v); chk("R4", "final dram addr", v, 32'h8000_0050);
    rd(3'd3, v); chk("R4", "final length", v, 32'h0);
    rd(3'd0, v); chk("R4", "control readback", v, 32'h0000_00F9);
    chk("R9", "irq with enable", 32'(irq), 32'h1);
    rd(3'd5, v); chk("R9", "interrupt register", v, 32'h0000_0808);
    wr(3'd5, 32'h0);
    chk("R9", "irq kept after status rewrite", 32'(irq), 32'h1);
    stopEngine();
    chk("R12", "irq after stop", 32'(irq), 32'h0);
  endtask

  task automatic testCopyToFlash();
    logic [31:0] v;
    wr(3'd2, 32'h50); wr(3'd1, 32'hA0); wr(3'd3, 32'hC);
    wr(3'd0, 32'h3);
    waitDone("R5");
    for (int i = 0; i < 3; i++)
      chk("R5", $sformatf("flash word %0d", i), fMem[40+i], dMem[20+i]);
    rd(3'd2, v); chk("R5", "final dram addr", v, 32'h8000_005C);
    chk("R9", "irq without enable", 32'(irq), 32'h0);
    // restart while status is still set
    wr(3'd2, 32'h60); wr(3'd1, 32'hC0); wr(3'd3, 32'h4);
    wr(3'd0, 32'h3);
    rd(3'd5, v); chk("R11", "status cleared by accepted start", 32'(v[11]), 32'h0);
    waitDone("R11");
    chk("R11", "restart moved word", fMem[48], dMem[24]);
    stopEngine();
  endtask

  task automatic testChecksum();
    logic [31:0] v;
    logic [31:0] exp = 32'h0;
    int d0 = dramAcc;
    for (int i = 0; i < 4; i++) exp = exp + fMem[8+i];
    wr(3'd1, 32'h20); wr(3'd2, 32'h44); wr(3'd3, 32'h10);
    wr(3'd0, 32'h5);
    waitDone("R6");
    rd(3'd4, v); chk("R6", "checksum", v, exp);
    rd(3'd2, v); chk("R6", "dram addr untouched", v, 32'h8000_0044);
    rd(3'd1, v); chk("R6", "flash addr advanced", v, 32'h2000_0030);
    chk("R6", "no dram access", 32'(dramAcc - d0), 32'h0);
    stopEngine();
    rd(3'd4, v); chk("R12", "checksum cleared by stop", v, 32'h0);
  endtask

  task automatic testInvalidAndZero();
    logic [31:0] v;
    int f0, d0;
    wr(3'd1, 32'h20); wr(3'd3, 32'h8);
    f0 = flashAcc; d0 = dramAcc;
    wr(3'd0, 32'h7);
    waitDone("R7");
    rd(3'd3, v); chk("R7", "length unchanged", v, 32'h8);
    rd(3'd1, v); chk("R7", "flash addr unchanged", v, 32'h2000_0020);
    chk("R7", "no access", 32'((flashAcc - f0) + (dramAcc - d0)), 32'h0);
    stopEngine();
    wr(3'd3, 32'h0);
    f0 = flashAcc; d0 = dramAcc;
    wr(3'd0, 32'h1);
    waitDone("R8");
    chk("R8", "no access for zero length", 32'((flashAcc - f0) + (dramAcc - d0)), 32'h0);
    stopEngine();
  endtask

  task automatic testError();
    logic [31:0] v;
    wr(3'd1, 32'h20); wr(3'd2, 32'h80); wr(3'd3, 32'h10);
    errAddr = 32'h2000_0028; errEn = 1'b1;
    wr(3'd0, 32'h1);
    waitDone("R13");
    errEn = 1'b0;
    rd(3'd1, v); chk("R13", "flash addr at failing word", v, 32'h2000_0028);
    rd(3'd2, v); chk("R13", "dram addr at failing word", v, 32'h8000_0088);
    rd(3'd3, v); chk("R13", "length at failing word", v, 32'h8);
    stopEngine();
  endtask

  task automatic testAbort();
    logic [31:0] v, lenSnap;
    int f0, d0;
    wr(3'd1, 32'h0); wr(3'd2, 32'h0); wr(3'd3, 32'h40);
    wr(3'd0, 32'h1);
    repeat (7) @(negedge clk);
    stopEngine();
    repeat (4) @(negedge clk);
    f0 = flashAcc; d0 = dramAcc;
    rd(3'd3, lenSnap);
    repeat (20) @(negedge clk);
    chk("R12", "no access after abort", 32'((flashAcc - f0) + (dramAcc - d0)), 32'h0);
    rd(3'd3, v); chk("R12", "length frozen after abort", v, lenSnap);
    chk("R12", "length partly consumed", 32'(v != 32'h0 && v != 32'h40), 32'h1);
    rd(3'd5, v); chk("R12", "status clear after abort", 32'(v[11]), 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      fMem[i] = 32'hF000_0000 + 32'(i) * 32'h0111_1111;
      dMem[i] = 32'h1234_0000 + 32'(i);
    end
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testMasks();
    testCopyToDram();
    testCopyToFlash();
    testChecksum();
    testInvalidAndZero();
    testError();
    testAbort();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule